// File: doc/BRIEF.md
# Biphase-Mark Line Receiver with Activity Detection

This block sits behind the comparator of a single configuration-channel wire that carries biphase-mark-coded traffic at roughly 300 kbit/s. It takes the digitized line level, runs it through a synchronizer, and oversamples it with a fast system clock. It recovers data bits by timing the gaps between transitions. Every cell opens with a transition. A cell that also holds an interior transition carries a 1, and a cell without one carries a 0. Each recovered bit is presented for one cycle together with a valid strobe.

A second path watches the same transitions and raises a bus-busy flag once enough transitions fall inside a bounded window of time. Higher layers use this flag to tell traffic from an idle line before they try to transmit. Framing, symbol decoding and CRC are left to the logic downstream.

The unit interval and the window length are given in system-clock cycles. The interior-edge limit is three quarters of a unit interval and the lock-loss limit is one and a half unit intervals. Both are derived from the unit interval.

Top module: `bmc_rx`

## Requirements
- R1: After reset, bit_valid, bit_data and bus_busy are all 0.
- R2: The first line transition after reset, or after lock has been lost, opens a cell and acquires lock without producing a bit.
- R3: A transition that arrives at least MID = (3*UI_CYC)/4 cycles after the cell start, in a cell with no interior transition, closes the cell and reports bit_data = 0. With UI_CYC = 80, MID is 60.
- R4: A transition that arrives fewer than MID cycles after the cell start is an interior transition. The next transition closes the cell and reports bit_data = 1.
- R5: Encoded traffic is decoded without error at unit intervals from 73 to 89 cycles when UI_CYC = 80. This corresponds to 330 down to 270 kbit/s.
- R6: If no closing transition arrives within LOCK = (3*UI_CYC)/2 cycles of the cell start, lock is dropped and no bit is reported. A closing transition exactly LOCK cycles after the start still closes the cell. With UI_CYC = 80, LOCK is 120.
- R7: bus_busy rises once three transitions occur with fewer than WIN_CYC cycles from the first to the third.
- R8: bus_busy stays low when three transitions are spread over WIN_CYC cycles or more, and when only two transitions occur.
- R9: bus_busy stays high while traffic continues and falls about WIN_CYC cycles after the last transition.
- R10: bit_valid is a one-cycle pulse, and bit_data is meaningful while bit_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Digitized line level, asynchronous to clk |
| bit_valid | output | 1 | One-cycle strobe for a recovered bit |
| bit_data | output | 1 | Recovered bit value |
| bus_busy | output | 1 | Line carries activity |

## Verification
The hardest states to reach are those where a transition lands exactly on a decision limit. Examples are one cycle before or at the interior-edge limit, exactly at or one past the lock-loss limit, and three transitions whose span is one cycle shorter than the busy window or equal to it. Normal traffic never lands there. The bench therefore drives the line with a cycle-exact toggle task that places each transition a chosen number of clocks after the previous one. Because the synchronizer delays every transition by the same amount, the spacing on the line equals the spacing the decoder sees.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;
  // Interior-edge limit: transitions earlier than this are mid-cell.
  function automatic int unsigned mid_limit(int unsigned ui);
    return (ui * 3) / 4;
  endfunction

  // Lock-loss limit measured from the cell start.
  function automatic int unsigned lock_limit(int unsigned ui);
    return (ui * 3) / 2;
  endfunction

  // Counter width able to hold values up to lim + 1.
  function automatic int unsigned count_width(int unsigned lim);
    return $clog2(lim + 2);
  endfunction
endpackage

// File: rtl/bmc_rx_sync.sv
module bmc_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_edge
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= chain[STAGES-1];
  end

  assign line_edge = chain[STAGES-1] ^ last_lvl;
endmodule

// File: rtl/bmc_rx_activity.sv
module bmc_rx_activity #(
  parameter int unsigned WIN_CYC    = 384,
  parameter int unsigned BUSY_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_edge,
  output logic bus_busy
);
  import bmc_rx_pkg::*;
  localparam int unsigned AW   = count_width(WIN_CYC);
  localparam int unsigned AGES = BUSY_EDGES - 1;
  localparam logic [AW-1:0] WIN_V = WIN_CYC[AW-1:0];

  // age[k]: cycles since the (k+1)-th most recent transition, saturating.
  logic [AW-1:0] age [AGES];

  generate
    for (genvar k = 0; k < AGES; k++) begin : g_age
      if (k == 0) begin : g_newest
        always_ff @(posedge clk) begin
          if (!rst_n)                 age[0] <= WIN_V;
          else if (line_edge)         age[0] <= AW'(1);
          else if (age[0] < WIN_V)    age[0] <= age[0] + AW'(1);
        end
      end else begin : g_older
        always_ff @(posedge clk) begin
          if (!rst_n)                  age[k] <= WIN_V;
          else if (line_edge)          age[k] <= (age[k-1] < WIN_V) ? age[k-1] + AW'(1) : WIN_V;
          else if (age[k] < WIN_V)     age[k] <= age[k] + AW'(1);
        end
      end
    end
  endgenerate

  logic burst_hit, quiet_out;
  assign burst_hit = line_edge && (age[AGES-1] < WIN_V);
  assign quiet_out = !line_edge && (age[0] >= WIN_V);

  always_ff @(posedge clk) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (burst_hit) bus_busy <= 1'b1;
    else if (quiet_out) bus_busy <= 1'b0;
  end
endmodule

// File: rtl/bmc_rx_decoder.sv
module bmc_rx_decoder #(
  parameter int unsigned UI_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_edge,
  output logic locked,
  output logic bit_valid,
  output logic bit_data
);
  import bmc_rx_pkg::*;
  localparam int unsigned MID  = mid_limit(UI_CYC);
  localparam int unsigned LOCK = lock_limit(UI_CYC);
  localparam int unsigned CW   = count_width(LOCK);
  localparam logic [CW-1:0] MID_V  = MID[CW-1:0];
  localparam logic [CW-1:0] LOCK_V = LOCK[CW-1:0];

  logic [CW-1:0] cell_cnt;
  logic          mid_seen;
  logic          open_cell, early_edge, cell_close, lock_lost;

  assign open_cell  = line_edge && !locked;
  assign early_edge = line_edge && locked && !mid_seen && (cell_cnt < MID_V);
  assign cell_close = line_edge && locked && !early_edge;
  assign lock_lost  = !line_edge && locked && (cell_cnt >= LOCK_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      cell_cnt <= '0;
      mid_seen <= 1'b0;
    end else if (open_cell || cell_close) begin
      locked   <= 1'b1;
      cell_cnt <= CW'(1);
      mid_seen <= 1'b0;
    end else if (lock_lost) begin
      locked   <= 1'b0;
      mid_seen <= 1'b0;
    end else if (locked) begin
      cell_cnt <= cell_cnt + CW'(1);
      if (early_edge) mid_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= cell_close;
      bit_data  <= cell_close ? mid_seen : 1'b0;
    end
  end
endmodule

// File: rtl/bmc_rx.sv
module bmc_rx #(
  parameter int unsigned UI_CYC      = 80,
  parameter int unsigned WIN_CYC     = 384,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BUSY_EDGES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_valid,
  output logic bit_data,
  output logic bus_busy
);
  logic line_edge;
  logic locked;

  bmc_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_edge(line_edge)
  );

  bmc_rx_decoder #(.UI_CYC(UI_CYC)) dec_i (
    .clk(clk), .rst_n(rst_n), .line_edge(line_edge),
    .locked(locked), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  bmc_rx_activity #(.WIN_CYC(WIN_CYC), .BUSY_EDGES(BUSY_EDGES)) act_i (
    .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .bus_busy(bus_busy)
  );
endmodule

// File: rtl/bmc_rx_chk.sv
module bmc_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic line_edge,
  input logic locked,
  input logic bit_valid,
  input logic bus_busy
);
  // R2/R10: a bit is only reported right after a transition seen while locked
  p_valid_after_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(line_edge) && $past(locked)));

  // R10: strobe lasts one cycle (transitions are never one cycle apart in a cell)
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid || $past(line_edge));

  // R6: lock is only lost in a cycle without a transition
  p_unlock_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !$past(line_edge));

  // R6: losing lock never reports a bit
  p_unlock_nobit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !bit_valid);

  // R7: busy rises only on a transition
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(line_edge));

  // R9: busy falls only in a quiet cycle
  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> !$past(line_edge));
endmodule

bind bmc_rx bmc_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .locked(locked),
  .bit_valid(bit_valid), .bus_busy(bus_busy)
);

// File: tb/bmc_rx_tb_top.sv
module bmc_rx_tb_top;
  localparam int UI  = 80;
  localparam int WIN = 384;
  localparam int MIDL = UI * 3 / 4;   // 60
  localparam int LCK  = UI * 3 / 2;   // 120

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_valid, bit_data, bus_busy;

  always #2 clk = ~clk;

  bmc_rx #(.UI_CYC(UI), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .bit_valid(bit_valid), .bit_data(bit_data), .bus_busy(bus_busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit got[$];
  bit prev_valid = 1'b0;
  int dbl_valid  = 0;

  always @(negedge clk) begin
    if (bit_valid) got.push_back(bit_data);
    if (bit_valid && prev_valid) dbl_valid++;
    prev_valid = bit_valid;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tog_after(int n);
    repeat (n) @(negedge clk);
    line = ~line;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a packet with unit interval u, then check decoded bits and busy.
  task automatic run_pkt(logic [63:0] pat, int n, int u, string tag);
    int base;
    base = got.size();
    tog_after(1);                       // opening edge of first cell
    for (int i = 0; i < n; i++) begin
      if (pat[i]) begin
        tog_after(u / 2);
        tog_after(u - u / 2);
      end else begin
        tog_after(u);
      end
    end
    idle(5);
    check({"R9 busy during traffic ", tag}, bus_busy, 1);
    idle(WIN - 15);
    check({"R9 busy held before window ", tag}, bus_busy, 1);
    idle(20);
    check({"R9 busy dropped after window ", tag}, bus_busy, 0);
    idle(WIN);
    check({"R5 bit count ", tag}, got.size() - base, n);
    for (int i = 0; i < n; i++) begin
      if (base + i < got.size())
        check(pat[i] ? {"R4 bit ", tag} : {"R3 bit ", tag}, got[base + i], pat[i]);
    end
  endtask

  initial begin
    logic [63:0] lf;
    int base;
    idle(4);
    check("R1 bit_valid", bit_valid, 0);
    check("R1 bit_data", bit_data, 0);
    check("R1 bus_busy", bus_busy, 0);
    rst_n = 1'b1;
    idle(4);

    // R5: several patterns at slow, nominal and fast rates
    lf = 64'h1;
    for (int r = 0; r < 3; r++) begin
      int u;
      u = (r == 0) ? 89 : (r == 1) ? 80 : 73;
      run_pkt(64'h0, 16, u, "zeros");
      run_pkt(64'hFFFF, 16, u, "ones");
      run_pkt(64'hAAAA_AAAA, 32, u, "alternating");
      for (int k = 0; k < 24; k++) lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      run_pkt(lf, 24, u, "lfsr");
    end

    // R3/R4 limits: interior edge at MID-1, closing edge at exactly MID
    base = got.size();
    tog_after(1);
    tog_after(MIDL - 1);          // interior
    tog_after(UI - MIDL + 1);     // closes -> 1
    tog_after(MIDL);              // closes -> 0
    tog_after(UI);                // closes -> 0
    idle(2 * WIN);
    check("R4 limit count", got.size() - base, 3);
    if (got.size() - base == 3) begin
      check("R4 interior at MID-1", got[base], 1);
      check("R3 close at MID", got[base + 1], 0);
      check("R3 close at UI", got[base + 2], 0);
    end

    // R6/R2: close at exactly LOCK, then gap of LOCK+1 drops lock
    base = got.size();
    tog_after(1);
    tog_after(LCK);               // closes -> 0
    tog_after(LCK + 1);           // lock lost earlier, reopens without bit
    tog_after(UI);                // closes -> 0
    idle(2 * WIN);
    check("R6 timeout count", got.size() - base, 2);
    if (got.size() - base == 2) begin
      check("R6 close at LOCK", got[base], 0);
      check("R2 relock bit", got[base + 1], 0);
    end

    // R7: three edges spanning WIN-1
    base = got.size();
    tog_after(1);
    tog_after(191);
    tog_after(192);
    idle(6);
    check("R7 busy span WIN-1", bus_busy, 1);
    idle(2 * WIN);
    check("R9 busy cleared", bus_busy, 0);

    // R8: three edges spanning exactly WIN
    tog_after(1);
    tog_after(192);
    tog_after(192);
    idle(6);
    check("R8 busy span WIN", bus_busy, 0);
    idle(50);
    check("R8 busy span WIN late", bus_busy, 0);
    idle(2 * WIN);

    // R8: only two close edges
    tog_after(1);
    tog_after(10);
    idle(20);
    check("R8 two edges", bus_busy, 0);
    idle(2 * WIN);
    check("R2 wide gaps give no bits", got.size() - base, 0);

    check("R10 single-cycle strobe", dbl_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule